// File: doc/BRIEF.md
# Reset Sequencer with Cause Flags

This block combines four reset sources into one system reset and decides when the CPU may start running. The sources are a power-on trip, an active-high external reset pin, a watchdog expiry and an internal boot-integrity failure. A power-on or external reset starts a timed handshake on two programming pins. The handshake is timed in sleep-clock ticks and lets an external programmer synchronise with the chip. A watchdog or internal reset skips the handshake and releases the CPU on the first sleep tick after the source goes away.

A small register port lets firmware read which source caused the last reset. Firmware clears a cause flag by writing 1 to its bit, and it sets or clears the watchdog enable in the same port. Any reset clears the enable. A power-on reset clears every cause flag and sets only its own flag. The other sources add their flag to the ones already set.

Top module: `reset_sequencer`

## Requirements
- R1: While any effective source is asserted, `cpu_run_o` is 0 and `sys_rst_o` is 1 from the next clock edge on. During a power-on or external hold, pin 0 is strong high and pin 1 is resistive low.
- R2: Each pin has a 2-bit drive mode: 00 high-impedance, 01 resistive low, 10 strong high. The code 11 (strong low) is never driven.
- R3: After a power-on or external reset releases, pin 0 stays strong high and pin 1 resistive low until the 256th sleep tick. At the clock edge that samples the 256th tick, pin 0 switches to resistive low.
- R4: At the edge that samples the 512th tick after release, both pins go high-impedance and `cpu_run_o` rises. Whenever `cpu_run_o` is 1, both pins are high-impedance.
- R5: Sleep ticks that arrive while a source is still asserted do not advance the sequence. The 256 and 512 tick counts start only after every source has deasserted.
- R6: A watchdog expiry resets the chip only when the enable (status 0, bit 7) is 1. With the enable at 0, the expiry has no effect. Every reset clears the enable.
- R7: A watchdog or internal reset leaves both pins high-impedance. `cpu_run_o` rises at the edge that samples the first sleep tick after the source deasserts.
- R8: Address 0 reads {enable, 4'b0, watchdog flag, external flag, power-on flag}, with bit 0 the power-on flag. Address 1 reads {7'b0, internal flag}.
- R9: A power-on reset leaves exactly the power-on flag set and the other flags cleared. External, watchdog and internal resets set their own flag and keep the flags already set.
- R10: Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged. Bit 7 of address 0 is written as data. Writes are ignored while `cpu_run_o` is 0.
- R11: A source that asserts part-way through the handshake restarts it from the hold state. The full 512-tick sequence then runs again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low register initialisation |
| por_i | input | 1 | Power-on trip, active high |
| xres_i | input | 1 | External reset pin, active high |
| wdt_expire_i | input | 1 | Watchdog expiry request |
| boot_fail_i | input | 1 | Internal boot-integrity failure |
| sleep_tick_i | input | 1 | One-cycle pulse per sleep-clock period |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register select (0 or 1) |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for the selected register |
| pin0_mode_o | output | 2 | Drive mode of handshake pin 0 |
| pin1_mode_o | output | 2 | Drive mode of handshake pin 1 |
| wdt_en_o | output | 1 | Watchdog reset enable |
| sys_rst_o | output | 1 | System reset, active high |
| cpu_run_o | output | 1 | CPU may execute |

## Verification
The assertions check these rules on every cycle:
- Any effective source stops the CPU on the next edge, and the enable is cleared on that edge.
- A power-on reset leaves only its own flag set.
- The flags hold their value when no source is asserted and no write is made.
- The strong-low code never appears on a pin.
- The pins float whenever the CPU runs.
- The CPU starts only from the end of the handshake or from the short wait.
- Once running, the CPU stays running through a masked watchdog expiry.

The exact 256-tick and 512-tick boundaries, the frozen count during a hold, the restart part-way through the handshake and the register bit layout can only be shown by the bench. It steps through each handshake one tick at a time and compares the pin modes after every tick.

// File: rtl/reset_seq_pkg.sv
package reset_seq_pkg;

  typedef enum logic [2:0] {
    ST_HOLD  = 3'd0,
    ST_PH1   = 3'd1,
    ST_PH2   = 3'd2,
    ST_SHORT = 3'd3,
    ST_RUN   = 3'd4
  } seq_state_e;

  typedef enum logic [1:0] {
    PM_HIZ       = 2'b00,
    PM_RES_LO    = 2'b01,
    PM_STRONG_HI = 2'b10,
    PM_STRONG_LO = 2'b11
  } pin_mode_e;

  // status 0 bit positions
  localparam int unsigned BIT_POR    = 0;
  localparam int unsigned BIT_EXT    = 1;
  localparam int unsigned BIT_WDT    = 2;
  localparam int unsigned BIT_WDT_EN = 7;
  // status 1 bit positions
  localparam int unsigned BIT_INT    = 0;

endpackage

// File: rtl/rst_cause_regs.sv
module rst_cause_regs
  import reset_seq_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              por_i,
  input  logic              ext_i,
  input  logic              wdt_i,
  input  logic              int_i,
  input  logic              wr_en_i,
  input  logic              addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              wdt_en_o
);

  logic por_q, ext_q, wdt_q, int_q, en_q;
  logic any_src;

  assign any_src = por_i | ext_i | wdt_i | int_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      por_q <= 1'b0;
      ext_q <= 1'b0;
      wdt_q <= 1'b0;
      int_q <= 1'b0;
      en_q  <= 1'b0;
    end else if (por_i) begin
      por_q <= 1'b1;
      ext_q <= 1'b0;
      wdt_q <= 1'b0;
      int_q <= 1'b0;
      en_q  <= 1'b0;
    end else if (any_src) begin
      ext_q <= ext_q | ext_i;
      wdt_q <= wdt_q | wdt_i;
      int_q <= int_q | int_i;
      en_q  <= 1'b0;
    end else if (wr_en_i) begin
      if (!addr_i) begin
        por_q <= por_q & ~wdata_i[BIT_POR];
        ext_q <= ext_q & ~wdata_i[BIT_EXT];
        wdt_q <= wdt_q & ~wdata_i[BIT_WDT];
        en_q  <= wdata_i[BIT_WDT_EN];
      end else begin
        int_q <= int_q & ~wdata_i[BIT_INT];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (!addr_i) begin
      rdata_o[BIT_POR]    = por_q;
      rdata_o[BIT_EXT]    = ext_q;
      rdata_o[BIT_WDT]    = wdt_q;
      rdata_o[BIT_WDT_EN] = en_q;
    end else begin
      rdata_o[BIT_INT]    = int_q;
    end
  end

  assign wdt_en_o = en_q;

  logic unused_wdata;
  assign unused_wdata = ^wdata_i;

  // R9: power-on leaves only its own flag
  a_r9_por_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    por_i |=> (por_q && !ext_q && !wdt_q && !int_q));

  // R6: any reset drops the watchdog enable
  a_r6_en_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_src |=> !en_q);

  // R10: flags change only through a source or a write
  a_r10_flags_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!any_src && !wr_en_i) |=> $stable({por_q, ext_q, wdt_q, int_q}));

endmodule

// File: rtl/rst_seq_fsm.sv
module rst_seq_fsm
  import reset_seq_pkg::*;
#(
  parameter int unsigned PHASE_TICKS = 256
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       src_any_i,
  input  logic       long_i,
  input  logic       tick_i,
  output seq_state_e state_o,
  output logic       long_o
);

  localparam int unsigned CNT_W = $clog2(PHASE_TICKS) + 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PHASE_TICKS - 1);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             long_q, long_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    long_d  = long_q;
    if (src_any_i) begin
      state_d = ST_HOLD;
      cnt_d   = '0;
      long_d  = (state_q == ST_HOLD) ? (long_q | long_i) : long_i;
    end else begin
      unique case (state_q)
        ST_HOLD: begin
          state_d = long_q ? ST_PH1 : ST_SHORT;
          cnt_d   = '0;
        end
        ST_PH1, ST_PH2: begin
          if (tick_i) begin
            if (cnt_q == CNT_LAST) begin
              state_d = (state_q == ST_PH1) ? ST_PH2 : ST_RUN;
              cnt_d   = '0;
            end else begin
              cnt_d = cnt_q + CNT_W'(1);
            end
          end
        end
        ST_SHORT: if (tick_i) state_d = ST_RUN;
        default:  state_d = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_HOLD;
      cnt_q   <= '0;
      long_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      long_q  <= long_d;
    end
  end

  assign state_o = state_q;
  assign long_o  = long_q;

  // R4, R7: the CPU starts only from the end of a sequence
  a_r4_run_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_RUN && state_d == ST_RUN) |-> (state_q == ST_PH2 || state_q == ST_SHORT));

  // R3: no phase advance without a tick
  a_r3_tick_needed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PH1 && !tick_i && !src_any_i) |=> state_q == ST_PH1);

  // R5: the count stays cleared while a source is asserted
  a_r5_count_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_any_i |=> cnt_q == '0);

endmodule

// File: rtl/hs_pin_decode.sv
module hs_pin_decode
  import reset_seq_pkg::*;
(
  input  seq_state_e state_i,
  input  logic       long_i,
  output logic [1:0] pin0_o,
  output logic [1:0] pin1_o,
  output logic       run_o
);

  pin_mode_e p0, p1;

  always_comb begin
    p0 = PM_HIZ;
    p1 = PM_HIZ;
    unique case (state_i)
      ST_HOLD: if (long_i) begin
        p0 = PM_STRONG_HI;
        p1 = PM_RES_LO;
      end
      ST_PH1: begin
        p0 = PM_STRONG_HI;
        p1 = PM_RES_LO;
      end
      ST_PH2: begin
        p0 = PM_RES_LO;
        p1 = PM_RES_LO;
      end
      default: ;
    endcase
  end

  assign pin0_o = p0;
  assign pin1_o = p1;
  assign run_o  = (state_i == ST_RUN);

endmodule

// File: rtl/reset_sequencer.sv
module reset_sequencer
  import reset_seq_pkg::*;
#(
  parameter int unsigned PHASE_TICKS = 256,
  parameter int unsigned DATA_W      = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              por_i,
  input  logic              xres_i,
  input  logic              wdt_expire_i,
  input  logic              boot_fail_i,
  input  logic              sleep_tick_i,
  input  logic              reg_wr_i,
  input  logic              reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic [1:0]        pin0_mode_o,
  output logic [1:0]        pin1_mode_o,
  output logic              wdt_en_o,
  output logic              sys_rst_o,
  output logic              cpu_run_o
);

  logic       wdt_hit, src_any, long_src, run, long_q;
  seq_state_e state;

  assign wdt_hit  = wdt_expire_i & wdt_en_o;
  assign src_any  = por_i | xres_i | wdt_hit | boot_fail_i;
  assign long_src = por_i | xres_i;

  rst_cause_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .por_i    (por_i),
    .ext_i    (xres_i),
    .wdt_i    (wdt_hit),
    .int_i    (boot_fail_i),
    .wr_en_i  (reg_wr_i & run),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .rdata_o  (reg_rdata_o),
    .wdt_en_o (wdt_en_o)
  );

  rst_seq_fsm #(.PHASE_TICKS(PHASE_TICKS)) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .src_any_i (src_any),
    .long_i    (long_src),
    .tick_i    (sleep_tick_i),
    .state_o   (state),
    .long_o    (long_q)
  );

  hs_pin_decode u_pins (
    .state_i (state),
    .long_i  (long_q),
    .pin0_o  (pin0_mode_o),
    .pin1_o  (pin1_mode_o),
    .run_o   (run)
  );

  assign cpu_run_o = run;
  assign sys_rst_o = ~run;

  // R1: a source stops the CPU on the next edge
  a_r1_src_halts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_any |=> (!cpu_run_o && sys_rst_o));

  // R2: strong low never driven
  a_r2_no_strong_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin0_mode_o != 2'b11) && (pin1_mode_o != 2'b11));

  // R4: pins float while running
  a_r4_run_floats: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_run_o |-> (pin0_mode_o == 2'b00 && pin1_mode_o == 2'b00));

  // R6: masked watchdog expiry leaves the CPU running
  a_r6_wdt_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_run_o && wdt_expire_i && !wdt_en_o && !por_i && !xres_i && !boot_fail_i) |=> cpu_run_o);

endmodule

// File: tb/tb_reset_sequencer.sv
module tb_reset_sequencer;

  logic       clk = 1'b0;
  logic       rst_ni, por, xres, wdt_exp, boot_fail, tick, wr, addr;
  logic [7:0] wdata, rdata;
  logic [1:0] p0, p1;
  logic       wdt_en, sys_rst, run;
  int         n_cmp = 0, n_bad = 0;
  bit         done = 0;

  always #2 clk = ~clk;

  reset_sequencer dut (
    .clk_i(clk), .rst_ni(rst_ni), .por_i(por), .xres_i(xres),
    .wdt_expire_i(wdt_exp), .boot_fail_i(boot_fail), .sleep_tick_i(tick),
    .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .pin0_mode_o(p0), .pin1_mode_o(p1), .wdt_en_o(wdt_en),
    .sys_rst_o(sys_rst), .cpu_run_o(run)
  );

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_tick();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    cyc(2);
  endtask

  task automatic wr_reg(input logic a, input logic [7:0] d);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic a, input logic [7:0] exp);
    addr = a;
    #1;
    check(req, rdata, exp);
  endtask

  // {pin0, pin1, run}: expected after the k-th tick of a long sequence (R3, R4)
  task automatic run_long(input string tag);
    for (int k = 1; k <= 512; k++) begin
      int exp;
      pulse_tick();
      if (k < 256)      exp = {2'b10, 2'b01, 1'b0};
      else if (k < 512) exp = {2'b01, 2'b01, 1'b0};
      else              exp = {2'b00, 2'b00, 1'b1};
      check((k < 512) ? {tag, " R3 phase"} : {tag, " R4 release"}, {p0, p1, run}, exp);
    end
  endtask

  initial begin
    rst_ni = 0; por = 1; xres = 0; wdt_exp = 0; boot_fail = 0;
    tick = 0; wr = 0; addr = 0; wdata = 0;
    cyc(2);
    rst_ni = 1;
    cyc(3);
    // R1 power-on hold
    check("R1 run", run, 0);
    check("R1 sys_rst", sys_rst, 1);
    check("R1 pins", {p0, p1}, 4'b1001);
    rd_check("R8 status0 after por", 0, 8'h01);
    rd_check("R8 status1 after por", 1, 8'h00);
    // R10 writes ignored in reset
    wr_reg(0, 8'h81);
    rd_check("R10 write during reset", 0, 8'h01);
    // R5 ticks during hold do not count
    for (int i = 0; i < 10; i++) pulse_tick();
    check("R5 hold pins", {p0, p1, run}, 5'b10010);
    por = 0;
    cyc(2);
    run_long("por");
    // R10 write-one-to-clear
    wr_reg(0, 8'h00);
    rd_check("R10 write zero keeps", 0, 8'h01);
    wr_reg(0, 8'h01);
    rd_check("R10 write one clears", 0, 8'h00);
    // R6 masked watchdog
    wdt_exp = 1; cyc(1); wdt_exp = 0; cyc(3);
    check("R6 masked run", run, 1);
    rd_check("R6 masked flags", 0, 8'h00);
    wr_reg(0, 8'h80);
    rd_check("R6 enable readback", 0, 8'h80);
    check("R6 wdt_en_o", wdt_en, 1);
    wdt_exp = 1; cyc(1); wdt_exp = 0;
    check("R6 wdt halts", run, 0);
    check("R7 wdt pins float", {p0, p1}, 4'b0000);
    cyc(3);
    check("R7 waits for tick", run, 0);
    rd_check("R6 enable cleared, R9 wdt flag", 0, 8'h04);
    pulse_tick();
    check("R7 wdt release", run, 1);
    // R9 external keeps wdt flag
    xres = 1; cyc(3);
    check("R1 ext pins", {p0, p1, run}, 5'b10010);
    rd_check("R9 ext sticky", 0, 8'h06);
    xres = 0; cyc(2);
    run_long("ext");
    // R11 restart during PH2
    xres = 1; cyc(1); xres = 0; cyc(2);
    for (int i = 0; i < 300; i++) pulse_tick();
    check("R11 in phase 2", {p0, p1}, 4'b0101);
    xres = 1; cyc(2);
    check("R11 back to hold", {p0, p1, run}, 5'b10010);
    xres = 0; cyc(2);
    run_long("restart R11");
    // R7 internal reset
    boot_fail = 1; cyc(3);
    check("R7 int pins", {p0, p1, run}, 5'b00000);
    rd_check("R8 int flag", 1, 8'h01);
    boot_fail = 0; cyc(2);
    check("R7 int waits", run, 0);
    pulse_tick();
    check("R7 int release", run, 1);
    wr_reg(1, 8'h01);
    rd_check("R10 int clear", 1, 8'h00);
    // R9 por clears all
    boot_fail = 1; cyc(1); boot_fail = 0; cyc(2);
    pulse_tick();
    por = 1; cyc(2);
    rd_check("R9 por status0", 0, 8'h01);
    rd_check("R9 por status1", 1, 8'h00);
    por = 0;
    cyc(2);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule